// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between the clock sources of a system clock generator and its output drivers. It receives a fast CPU-rate clock, a PCI-rate clock and a reference clock. It delivers a group of gated CPU clocks, a group of gated PCI clocks, one PCI clock that runs freely, and a group of gated reference clocks. It also drives the enables for the crystal oscillator and the PLL.

Three active-low requests arrive asynchronously. The first stops the CPU clocks, the second stops the gated PCI clocks, and the third powers the whole generator down. Each request is synchronised in the domain where it acts. Every gate uses an enable register clocked on the falling edge of its source, so each output either passes a full high phase or stays low. A stopped output always rests low.

Leaving power-down, and leaving reset, starts a settling counter that stands in for the start-up time of the oscillator and PLL. No output is released until that counter has expired.

Top module: `clk_stop_ctrl`

## Requirements
- R1: During reset and for SETTLE_CYCLES rising edges of `clk_pci_i` after reset is released, every clock output stays low while `osc_en_o` and `pll_en_o` are high. With the power-down request inactive, the first `pci_free_o` pulse comes on PCI edge SETTLE_CYCLES+1, counting the first edge after release as edge 1.
- R2: While `cpu_stop_n_i` is low, every `cpu_clk_o` bit stays low. The PCI, free-running PCI and reference outputs keep toggling.
- R3: While `pci_stop_n_i` is low, every `pci_clk_o` bit stays low. `pci_free_o`, the CPU outputs and the reference outputs keep toggling.
- R4: PCI stop latency is counted in free-running PCI edges, taking edge 1 as the first edge at which the changed request is sampled. After a request, the last `pci_clk_o` pulse is on edge 2. After a release, the first pulse is on edge 3.
- R5: CPU stop latency follows the same count on `clk_cpu_i` edges. After a request, the last CPU pulse is on edge 2. After a release, the first CPU pulse is on edge 3, so it comes no sooner than the third CPU edge.
- R6: While `pwr_dn_n_i` is low, the CPU, gated PCI and free-running PCI outputs are all low, whatever the two stop requests are. On entry, the last `pci_free_o` pulse is on PCI edge 2.
- R7: On power-down entry, `osc_en_o` and `pll_en_o` are still high after PCI edge 2 and are low after edge 3. The reference outputs stop through their own synchroniser in the reference domain, apart from the PCI count.
- R8: On release of power-down, `osc_en_o` and `pll_en_o` are high after PCI edge 3. `pci_free_o` stays low through edge 3+SETTLE_CYCLES and pulses first on edge 4+SETTLE_CYCLES. After that, all outputs resume.
- R9: Gating is glitch-free. The first output pulse after a gate opens lasts a full high phase of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | CPU-rate source clock |
| clk_pci_i | input | 1 | PCI-rate source clock; all latencies and the settling count use it |
| clk_ref_i | input | 1 | Reference-rate source clock |
| rst_i | input | 1 | Synchronous active-high reset, held over several cycles of every source |
| cpu_stop_n_i | input | 1 | Asynchronous request, low stops the CPU outputs |
| pci_stop_n_i | input | 1 | Asynchronous request, low stops the gated PCI outputs |
| pwr_dn_n_i | input | 1 | Asynchronous request, low powers the generator down |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_free_o | output | 1 | PCI clock that ignores the PCI stop request |
| ref_clk_o | output | N_REF | Gated reference clocks |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |

## Verification
Every latency is counted from the first rising edge of the governing source at which the changed request is sampled. The bench therefore drives each request just after a falling edge of that source, then samples the output 1 ns after each following rising edge, inside the high phase. At those points it expects the last pulse at edge 2 and the first pulse at edge 3 for stop and release, the enables to drop after edge 3 on power-down, and release at edge SETTLE_CYCLES+1 after reset or edge SETTLE_CYCLES+4 after power-up. For steady states, each stimulus row is given 40 PCI periods to settle, and the outputs are then judged by counting their rising edges over a further 10 periods.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    typedef enum logic [1:0] {
        PS_SETTLE = 2'd0,
        PS_RUN    = 2'd1,
        PS_DOWN   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic cpu;
        logic pci;
        logic pcif;
        logic refc;
    } gate_en_t;

    localparam int unsigned DEF_SYNC_STAGES  = 2;
    localparam int unsigned DEF_SETTLE       = 100000;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int unsigned N_OUT       = 1,
    parameter int unsigned N_REQ       = 1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [N_REQ-1:0] REQ_RST = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_REQ-1:0] req_i,
    output logic             en_o,
    output logic [N_OUT-1:0] gclk_o
);
    logic [N_REQ-1:0] req_s;
    logic             en_q;

    // Requests already in this domain skip the synchroniser.
    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign req_s = req_i;
        end else begin : g_sync
            clk_stop_sync #(
                .WIDTH  (N_REQ),
                .STAGES (SYNC_STAGES),
                .RST_VAL(REQ_RST)
            ) u_sync (
                .clk_i(clk_i),
                .rst_i(rst_i),
                .d_i  (req_i),
                .q_o  (req_s)
            );
        end
    endgenerate

    // The enable moves only on the falling edge, while the source is low,
    // so an output never carries a shortened high phase.
    always_ff @(negedge clk_i) begin
        if (rst_i) en_q <= 1'b0;
        else       en_q <= &req_s;
    end

    assign en_o = en_q;

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_out
            assign gclk_o[i] = clk_i & en_q;
        end
    endgenerate
endmodule

// File: rtl/clk_stop_seq.sv
module clk_stop_seq
    import clk_stop_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = DEF_SETTLE
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pd_s_i,
    output logic ready_o,
    output logic ready_q_o,
    output logic osc_en_o,
    output logic pll_en_o
);
    localparam int unsigned CW = cnt_width(SETTLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    pwr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ready_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_SETTLE: begin
                if (!pd_s_i)            state_d = PS_DOWN;
                else if (cnt_q == LAST) state_d = PS_RUN;
                else                    cnt_d   = cnt_q + 1'b1;
            end
            PS_RUN: begin
                if (!pd_s_i) state_d = PS_DOWN;
            end
            PS_DOWN: begin
                if (pd_s_i) begin
                    state_d = PS_SETTLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = PS_SETTLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PS_SETTLE;
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ready_q <= ready_o;
        end
    end

    assign ready_o   = (state_q == PS_RUN) && pd_s_i;
    assign ready_q_o = ready_q;
    assign osc_en_o  = (state_q != PS_DOWN);
    assign pll_en_o  = (state_q != PS_DOWN);
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clk_stop_pkg::*;
#(
    parameter int unsigned N_CPU         = 2,
    parameter int unsigned N_PCI         = 5,
    parameter int unsigned N_REF         = 2,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
    parameter int unsigned SETTLE_CYCLES = DEF_SETTLE
) (
    input  logic             clk_cpu_i,
    input  logic             clk_pci_i,
    input  logic             clk_ref_i,
    input  logic             rst_i,
    input  logic             cpu_stop_n_i,
    input  logic             pci_stop_n_i,
    input  logic             pwr_dn_n_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic [N_REF-1:0] ref_clk_o,
    output logic             osc_en_o,
    output logic             pll_en_o
);
    logic     pd_s, pci_stop_s;
    logic     ready, ready_q;
    gate_en_t en_s;
    logic [0:0] pci_free_vec;

    clk_stop_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_pci_sync (
        .clk_i(clk_pci_i),
        .rst_i(rst_i),
        .d_i  ({pwr_dn_n_i, pci_stop_n_i}),
        .q_o  ({pd_s, pci_stop_s})
    );

    clk_stop_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk_i    (clk_pci_i),
        .rst_i    (rst_i),
        .pd_s_i   (pd_s),
        .ready_o  (ready),
        .ready_q_o(ready_q),
        .osc_en_o (osc_en_o),
        .pll_en_o (pll_en_o)
    );

    clk_stop_gate #(.N_OUT(N_PCI), .N_REQ(1), .SYNC_STAGES(0), .REQ_RST(1'b0)) u_pci_gate (
        .clk_i (clk_pci_i),
        .rst_i (rst_i),
        .req_i (pci_stop_s & ready),
        .en_o  (en_s.pci),
        .gclk_o(pci_clk_o)
    );

    clk_stop_gate #(.N_OUT(1), .N_REQ(1), .SYNC_STAGES(0), .REQ_RST(1'b0)) u_free_gate (
        .clk_i (clk_pci_i),
        .rst_i (rst_i),
        .req_i (ready),
        .en_o  (en_s.pcif),
        .gclk_o(pci_free_vec)
    );
    assign pci_free_o = pci_free_vec[0];

    clk_stop_gate #(.N_OUT(N_CPU), .N_REQ(2), .SYNC_STAGES(SYNC_STAGES), .REQ_RST(2'b10)) u_cpu_gate (
        .clk_i (clk_cpu_i),
        .rst_i (rst_i),
        .req_i ({cpu_stop_n_i, ready_q}),
        .en_o  (en_s.cpu),
        .gclk_o(cpu_clk_o)
    );

    // The reference group watches the raw power-down request itself.
    clk_stop_gate #(.N_OUT(N_REF), .N_REQ(2), .SYNC_STAGES(SYNC_STAGES), .REQ_RST(2'b10)) u_ref_gate (
        .clk_i (clk_ref_i),
        .rst_i (rst_i),
        .req_i ({pwr_dn_n_i, ready_q}),
        .en_o  (en_s.refc),
        .gclk_o(ref_clk_o)
    );
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk (
    input logic clk_cpu_i,
    input logic clk_pci_i,
    input logic clk_ref_i,
    input logic rst_i,
    input logic cpu_stop_n_i,
    input logic pci_stop_n_i,
    input logic pwr_dn_n_i,
    input logic cpu_en_i,
    input logic pci_en_i,
    input logic pcif_en_i,
    input logic ref_en_i,
    input logic osc_en_i
);
    // R5: a CPU stop held over three CPU edges has closed the CPU gate
    a_r5_cpu_gate_closed: assert property (@(posedge clk_cpu_i) disable iff (rst_i)
        (!cpu_stop_n_i && !$past(cpu_stop_n_i) && !$past(cpu_stop_n_i, 2)) |-> !cpu_en_i);

    // R4: a PCI stop held over three PCI edges has closed the PCI gate
    a_r4_pci_gate_closed: assert property (@(posedge clk_pci_i) disable iff (rst_i)
        (!pci_stop_n_i && !$past(pci_stop_n_i) && !$past(pci_stop_n_i, 2)) |-> !pci_en_i);

    // R3: the free-running gate closes only after a power-down request
    a_r3_free_ignores_pci_stop: assert property (@(posedge clk_pci_i) disable iff (rst_i)
        $fell(pcif_en_i) |-> !$past(pwr_dn_n_i, 2));

    // R6: with the oscillator off no PCI-domain gate is open
    a_r6_down_gates_closed: assert property (@(posedge clk_pci_i) disable iff (rst_i)
        !osc_en_i |-> (!pcif_en_i && !pci_en_i));

    // R7: the reference gate follows power-down in its own domain
    a_r7_ref_gate_closed: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        (!pwr_dn_n_i && !$past(pwr_dn_n_i) && !$past(pwr_dn_n_i, 2)) |-> !ref_en_i);
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk u_chk (
    .clk_cpu_i   (clk_cpu_i),
    .clk_pci_i   (clk_pci_i),
    .clk_ref_i   (clk_ref_i),
    .rst_i       (rst_i),
    .cpu_stop_n_i(cpu_stop_n_i),
    .pci_stop_n_i(pci_stop_n_i),
    .pwr_dn_n_i  (pwr_dn_n_i),
    .cpu_en_i    (en_s.cpu),
    .pci_en_i    (en_s.pci),
    .pcif_en_i   (en_s.pcif),
    .ref_en_i    (en_s.refc),
    .osc_en_i    (osc_en_o)
);

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;
    localparam int unsigned S = 20;

    logic clk_cpu = 1'b0, clk_pci = 1'b0, clk_ref = 1'b0;
    logic rst = 1'b1;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [1:0] cpu_o;
    logic [4:0] pci_o;
    logic       free_o;
    logic [1:0] ref_o;
    logic       osc_en, pll_en;

    always #5  clk_cpu = ~clk_cpu;
    always #15 clk_pci = ~clk_pci;
    always #35 clk_ref = ~clk_ref;

    clk_stop_ctrl #(.N_CPU(2), .N_PCI(5), .N_REF(2), .SYNC_STAGES(2), .SETTLE_CYCLES(S)) dut_i (
        .clk_cpu_i(clk_cpu), .clk_pci_i(clk_pci), .clk_ref_i(clk_ref), .rst_i(rst),
        .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n), .pwr_dn_n_i(pwr_dn_n),
        .cpu_clk_o(cpu_o), .pci_clk_o(pci_o), .pci_free_o(free_o), .ref_clk_o(ref_o),
        .osc_en_o(osc_en), .pll_en_o(pll_en)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    int c_cpu = 0, c_pci = 0, c_free = 0, c_ref = 0;
    always @(posedge cpu_o[0]) c_cpu++;
    always @(posedge pci_o[0]) c_pci++;
    always @(posedge free_o)   c_free++;
    always @(posedge ref_o[0]) c_ref++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pedge(input int n);
        repeat (n) @(posedge clk_pci);
        #1;
    endtask

    task automatic cedge(input int n);
        repeat (n) @(posedge clk_cpu);
        #1;
    endtask

    // {cpu_stop_n, pci_stop_n, pwr_dn_n, run cpu, run pci, run free, run ref}
    localparam logic [6:0] VEC [7] = '{
        7'b111_1111,
        7'b011_0111,   // R2
        7'b101_1011,   // R3
        7'b001_0011,   // R2 R3
        7'b110_0000,   // R6 R7
        7'b000_0000,   // R6 override
        7'b111_1111
    };

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int s0c, s0p, s0f, s0r;
        realtime t0;
        // R1: reset state
        repeat (6) @(posedge clk_pci);
        #1;
        check("R1 reset outputs", int'({cpu_o, pci_o, free_o, ref_o}), 0);
        check("R1 reset osc_en", int'(osc_en), 1);
        check("R1 reset pll_en", int'(pll_en), 1);
        @(negedge clk_pci);
        rst = 1'b0;
        s0c = c_cpu; s0p = c_pci; s0f = c_free; s0r = c_ref;
        pedge(S);
        check("R1 free low at edge S", int'(free_o), 0);
        check("R1 no pulses while settling", (c_cpu-s0c)+(c_pci-s0p)+(c_free-s0f)+(c_ref-s0r), 0);
        pedge(1);
        check("R1 free first pulse at edge S+1", int'(free_o), 1);

        // steady-state table
        foreach (VEC[k]) begin
            @(negedge clk_pci);
            {cpu_stop_n, pci_stop_n, pwr_dn_n} = VEC[k][6:4];
            pedge(40);
            s0c = c_cpu; s0p = c_pci; s0f = c_free; s0r = c_ref;
            pedge(10);
            check($sformatf("R2 cpu run row%0d", k), int'(c_cpu != s0c), int'(VEC[k][3]));
            check($sformatf("R3 pci run row%0d", k), int'(c_pci != s0p), int'(VEC[k][2]));
            check($sformatf("R6 free run row%0d", k), int'(c_free != s0f), int'(VEC[k][1]));
            check($sformatf("R7 ref run row%0d", k), int'(c_ref != s0r), int'(VEC[k][0]));
            check($sformatf("R7 osc_en row%0d", k), int'(osc_en), int'(VEC[k][4]));
        end

        // R4: PCI stop and release latency
        @(negedge clk_pci); pci_stop_n = 1'b0;
        pedge(2); check("R4 last pci pulse at edge 2", int'(pci_o[0]), 1);
        pedge(1); check("R4 pci low at edge 3", int'(pci_o[0]), 0);
        check("R3 free unaffected", int'(free_o), 1);
        pedge(4);
        @(negedge clk_pci); pci_stop_n = 1'b1;
        pedge(2); check("R4 pci still low at edge 2", int'(pci_o[0]), 0);
        pedge(1); check("R4 first pci pulse at edge 3", int'(pci_o[0]), 1);

        // R5: CPU stop and release latency
        pedge(4);
        @(negedge clk_cpu); cpu_stop_n = 1'b0;
        cedge(2); check("R5 last cpu pulse at edge 2", int'(cpu_o[1]), 1);
        cedge(1); check("R5 cpu low at edge 3", int'(cpu_o[1]), 0);
        cedge(6);
        @(negedge clk_cpu); cpu_stop_n = 1'b1;
        cedge(2); check("R5 cpu still low at edge 2", int'(cpu_o[0]), 0);
        @(posedge clk_cpu); t0 = $realtime; #1;
        check("R5 first cpu pulse at edge 3", int'(cpu_o[0]), 1);
        @(negedge cpu_o[0]);
        check("R9 first cpu pulse width ns", int'($realtime - t0), 5);

        // R6/R7: power-down entry
        pedge(4);
        @(negedge clk_pci); pwr_dn_n = 1'b0;
        pedge(2);
        check("R6 last free pulse at edge 2", int'(free_o), 1);
        check("R7 osc_en still on at edge 2", int'(osc_en), 1);
        pedge(1);
        check("R6 free low at edge 3", int'(free_o), 0);
        check("R7 osc_en off at edge 3", int'(osc_en), 0);
        check("R7 pll_en off at edge 3", int'(pll_en), 0);
        pedge(8);
        s0r = c_ref; s0c = c_cpu;
        pedge(10);
        check("R7 ref stopped", c_ref - s0r, 0);
        check("R6 cpu stopped", c_cpu - s0c, 0);

        // R8: power-up and settling
        @(negedge clk_pci); pwr_dn_n = 1'b1;
        s0f = c_free;
        pedge(3);
        check("R8 osc_en on at edge 3", int'(osc_en), 1);
        check("R8 pll_en on at edge 3", int'(pll_en), 1);
        pedge(S);
        check("R8 free low at edge 3+S", int'(free_o), 0);
        check("R8 no free pulses while settling", c_free - s0f, 0);
        @(posedge clk_pci); t0 = $realtime; #1;
        check("R8 first free pulse at edge 4+S", int'(free_o), 1);
        @(negedge free_o);
        check("R9 first free pulse width ns", int'($realtime - t0), 15);
        pedge(20);
        s0c = c_cpu; s0p = c_pci; s0r = c_ref;
        pedge(10);
        check("R8 cpu resumed", int'(c_cpu != s0c), 1);
        check("R8 pci resumed", int'(c_pci != s0p), 1);
        check("R8 ref resumed", int'(c_ref != s0r), 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule